// File: doc/BRIEF.md
# UART Command and Register Block

This block is the software-facing side of a byte-oriented serial port. A processor reaches it over a simple byte-wide memory-mapped bus with select, write-enable, address and data lines. Read data is registered and appears one cycle after the access. Bit-level serialisation sits outside the block. Received bytes and line-break events arrive on a byte-level input. Bytes to be sent leave on a valid/ready output.

Software configures the port through two mode bytes that share one address. An internal pointer picks which of the two is reached. A packed command byte holds three fields: one enables or disables the transmitter, one does the same for the receiver, and one carries one-shot actions such as a direction reset or a pointer rewind. Received bytes queue in a small FIFO. A single transmit byte is held until the downstream side takes it. An interrupt status byte is ANDed with a mask byte and the result drives one interrupt line.

Top module: `uart_regblk`

## Requirements
- R1: After reset, status (offset 0x04) reads 0x08 (only transmitter-empty, bit 3, set), interrupt status (0x14) reads 0x00, both mode bytes are 0x00, irq is low and tx_valid is low.
- R2: Only address bits 5:0 are decoded, so offset 0x48 acts as 0x08. Offset 0x10 reads 0x00. A write to 0x04 has no effect. Offsets 0x18 and 0x1C are plain read/write bytes.
- R3: Offset 0x00 reaches mode byte 0 or 1, as chosen by a pointer that is 0 after reset. Each write there stores into the selected byte and then sets the pointer to 1. Command miscellaneous code 1 sets the pointer back to 0.
- R4: The command byte holds a miscellaneous field in bits 6:4, a transmit field in bits 3:2 and a receive field in bits 1:0. In the transmit and receive fields, code 1 enables that direction, code 2 disables it, and codes 0 and 3 leave it unchanged. A disabled transmitter holds its byte and does not offer it.
- R5: Miscellaneous code 2 disables the receiver, empties the FIFO and clears status bits 0 and 1. Code 3 disables the transmitter, drops any held byte and sets status bit 3.
- R6: Writing offset 0x0C stores a transmit byte and clears status bit 3. While the transmitter is enabled, the byte is offered on tx_valid/tx_data and held stable for any number of stall cycles. Status bit 3 is set again in the cycle tx_ready accepts the byte. Status bit 2 equals the transmitter-enable state.
- R7: The receive FIFO holds 4 bytes. Status bit 0 shows that it is non-empty and bit 1 shows that it is full. A read of offset 0x0C returns the oldest byte and removes it. A read of an empty FIFO returns 0x00.
- R8: A received byte is stored only if the receiver is enabled and the FIFO was not full at the start of that cycle. Otherwise it is dropped.
- R9: A break event sets interrupt status bit 2 and queues 0x00. If the FIFO is full and not being read in that cycle, the 0x00 replaces the newest entry. Miscellaneous code 5 clears bit 2.
- R10: Interrupt status bit 0 equals status bit 2. Interrupt status bit 1 equals status bit 1 when mode byte 0 bit 6 is set, and status bit 0 otherwise.
- R11: A write to offset 0x14 sets the mask. irq is high exactly when interrupt status AND mask is nonzero.
- R12: A FIFO read and an accepted received byte in the same cycle both take effect, and the FIFO occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; only bits 5:0 are decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line-break event pulse |
| tx_valid | output | 1 | A transmit byte is offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Downstream accepts the offered byte |

## Verification
The bench goes after the FIFO edges. It reads and receives at the same time, both with room in the FIFO, where a design with a bad count would lose or repeat bytes, and with the FIFO full, where a design that treats the pop as freeing space would store the extra byte. It sends a break into a full FIFO, where a wrong design would drop the zero or push out the oldest byte. It stalls the transmit byte for several cycles and checks that the byte and status bit 3 are held. It checks that a disabled transmitter keeps its byte and that code 3 drops it. It also checks the mode pointer after rewind, the switch of the receive-interrupt source between non-empty and full, and the address alias.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;
  localparam logic [5:0] OFS_MODE  = 6'h00;
  localparam logic [5:0] OFS_STAT  = 6'h04;
  localparam logic [5:0] OFS_CMD   = 6'h08;
  localparam logic [5:0] OFS_DATA  = 6'h0C;
  localparam logic [5:0] OFS_AUX   = 6'h10;
  localparam logic [5:0] OFS_INT   = 6'h14;
  localparam logic [5:0] OFS_BAUDA = 6'h18;
  localparam logic [5:0] OFS_BAUDB = 6'h1C;

  localparam int MODE0_RXSEL_BIT = 6;

  localparam logic [2:0] MISC_PTR_REWIND = 3'd1;
  localparam logic [2:0] MISC_RX_RESET   = 3'd2;
  localparam logic [2:0] MISC_TX_RESET   = 3'd3;
  localparam logic [2:0] MISC_BRK_CLEAR  = 3'd5;
  localparam logic [1:0] DIR_ON          = 2'd1;
  localparam logic [1:0] DIR_OFF         = 2'd2;

  typedef struct packed {
    logic ptr_rewind;
    logic rx_reset;
    logic tx_reset;
    logic brk_clear;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;
endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
  import uart_regblk_pkg::*;
(
  input  logic       en,
  input  logic [7:0] cmd,
  output cmd_act_t   act
);
  logic [2:0] misc;
  logic [1:0] txf, rxf;
  logic       unused_top;

  assign misc       = cmd[6:4];
  assign txf        = cmd[3:2];
  assign rxf        = cmd[1:0];
  assign unused_top = cmd[7];

  always_comb begin
    act            = '0;
    act.ptr_rewind = en && (misc == MISC_PTR_REWIND);
    act.rx_reset   = en && (misc == MISC_RX_RESET);
    act.tx_reset   = en && (misc == MISC_TX_RESET);
    act.brk_clear  = en && (misc == MISC_BRK_CLEAR);
    act.tx_on      = en && (txf == DIR_ON);
    act.tx_off     = en && (txf == DIR_OFF);
    act.rx_on      = en && (rxf == DIR_ON);
    act.rx_off     = en && (rxf == DIR_OFF);
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          ovw,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_prev;
  logic          do_pop, do_push, do_ovw;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && (!full || do_pop) && !flush;
  assign do_ovw  = ovw && full && !do_pop && !flush;
  assign wr_prev = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  assign dout    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
    else if (do_ovw) mem[wr_prev] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r12_pop_push_level: assert property (@(posedge clk) disable iff (rst)
    (pop && push && !empty && !full && !flush) |=> $stable(count));
  a_r9_ovw_stays_full: assert property (@(posedge clk) disable iff (rst)
    (ovw && full && !pop && !flush) |=> full);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic         enable,
  input  logic         drop,
  output logic         pending,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  input  logic         tx_ready
);
  logic fire;

  assign tx_valid = pending && enable;
  assign fire     = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      tx_data <= '0;
    end else begin
      if (load) tx_data <= ldata;
      if (drop)      pending <= 1'b0;
      else if (load) pending <= 1'b1;
      else if (fire) pending <= 1'b0;
    end
  end

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !load && !drop) |=> (pending && $stable(tx_data)));
  a_r6_accept_empties: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !load) |=> !pending);
endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
  import uart_regblk_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int RX_DEPTH = 4,
  localparam int DW     = 8,
  localparam int CW     = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_break,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_ready
);
  logic [5:0]    ofs;
  logic          wr, rd, unused_hi;
  logic [DW-1:0] mode0, mode1, imask, baud_a, baud_b;
  logic          mode_ptr, tx_en, rx_en, brk_flag;
  cmd_act_t      act;
  logic          pop_req, fifo_push, fifo_full, fifo_empty, tx_pending;
  logic [DW-1:0] fifo_dout, fifo_din, status, istat;
  logic [CW-1:0] fifo_count;

  assign ofs       = bus_addr[5:0];
  assign unused_hi = ^bus_addr;
  assign wr        = bus_sel && bus_we;
  assign rd        = bus_sel && !bus_we;
  assign pop_req   = rd && (ofs == OFS_DATA);

  uart_cmd_dec u_dec (
    .en  (wr && (ofs == OFS_CMD)),
    .cmd (bus_wdata),
    .act (act)
  );

  assign fifo_push = rx_break || (rx_valid && rx_en && !fifo_full);
  assign fifo_din  = rx_break ? '0 : rx_data;

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .W(DW)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (act.rx_reset),
    .push  (fifo_push),
    .ovw   (rx_break),
    .pop   (pop_req),
    .din   (fifo_din),
    .dout  (fifo_dout),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  uart_tx_hold #(.W(DW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .load     (wr && (ofs == OFS_DATA)),
    .ldata    (bus_wdata),
    .enable   (tx_en),
    .drop     (act.tx_reset),
    .pending  (tx_pending),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready)
  );

  assign status = {4'b0, !tx_pending, tx_en, fifo_full, !fifo_empty};
  assign istat  = {5'b0, brk_flag,
                   mode0[MODE0_RXSEL_BIT] ? fifo_full : !fifo_empty, tx_en};
  assign irq    = |(istat & imask);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode0 <= '0; mode1 <= '0; mode_ptr <= 1'b0;
      imask <= '0; baud_a <= '0; baud_b <= '0;
      tx_en <= 1'b0; rx_en <= 1'b0; brk_flag <= 1'b0;
    end else begin
      if (wr && ofs == OFS_MODE) begin
        if (mode_ptr) mode1 <= bus_wdata;
        else          mode0 <= bus_wdata;
        mode_ptr <= 1'b1;
      end
      if (act.ptr_rewind) mode_ptr <= 1'b0;
      if (wr && ofs == OFS_INT)   imask  <= bus_wdata;
      if (wr && ofs == OFS_BAUDA) baud_a <= bus_wdata;
      if (wr && ofs == OFS_BAUDB) baud_b <= bus_wdata;
      if (act.tx_reset) tx_en <= 1'b0;
      if (act.tx_on)       tx_en <= 1'b1;
      else if (act.tx_off) tx_en <= 1'b0;
      if (act.rx_reset) rx_en <= 1'b0;
      if (act.rx_on)       rx_en <= 1'b1;
      else if (act.rx_off) rx_en <= 1'b0;
      if (act.brk_clear) brk_flag <= 1'b0;
      if (rx_break)      brk_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd) begin
      case (ofs)
        OFS_MODE:  bus_rdata <= mode_ptr ? mode1 : mode0;
        OFS_STAT:  bus_rdata <= status;
        OFS_DATA:  bus_rdata <= fifo_dout;
        OFS_AUX:   bus_rdata <= '0;
        OFS_INT:   bus_rdata <= istat;
        OFS_BAUDA: bus_rdata <= baud_a;
        OFS_BAUDB: bus_rdata <= baud_b;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  a_r3_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    (wr && ofs == OFS_MODE) |=> mode_ptr);
  a_r8_drop_rejected: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_break && (!rx_en || fifo_full) && !pop_req && !act.rx_reset)
      |=> $stable(fifo_count));
  a_r11_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    irq |-> (imask != '0));
  a_r5_rx_reset_empties: assert property (@(posedge clk) disable iff (rst)
    act.rx_reset |=> (fifo_empty && !rx_en));
endmodule

// File: tb/uart_regblk_bench.sv
`timescale 1ns/1ps
module uart_regblk_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  int         total = 0, bad = 0;
  logic       finished = 1'b0;

  always #5 clk = ~clk;

  uart_regblk u_uart_regblk (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  // {write, req, addr, data-or-expected}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd1, 8'h04, 8'h08},  // R1 status
    {1'b0, 4'd1, 8'h14, 8'h00},  // R1 interrupt status
    {1'b0, 4'd1, 8'h00, 8'h00},  // R1 mode byte 0
    {1'b1, 4'd3, 8'h00, 8'h11},  // R3 mode 0
    {1'b1, 4'd3, 8'h00, 8'h22},  // R3 mode 1
    {1'b0, 4'd3, 8'h00, 8'h22},  // R3 pointer stays 1
    {1'b1, 4'd3, 8'h08, 8'h10},  // R3 rewind
    {1'b0, 4'd3, 8'h00, 8'h11},  // R3 back to mode 0
    {1'b1, 4'd2, 8'h18, 8'h5A},  // R2 baud a
    {1'b1, 4'd2, 8'h1C, 8'hA5},  // R2 baud b
    {1'b0, 4'd2, 8'h18, 8'h5A},  // R2
    {1'b0, 4'd2, 8'h1C, 8'hA5},  // R2
    {1'b1, 4'd2, 8'h04, 8'hFF},  // R2 status write ignored
    {1'b0, 4'd2, 8'h10, 8'h00},  // R2 zero offset
    {1'b1, 4'd4, 8'h08, 8'h04},  // R4 tx on
    {1'b0, 4'd10, 8'h14, 8'h01}, // R10 TxINT follows TxRDY
    {1'b1, 4'd2, 8'h48, 8'h08},  // R2 alias: tx off via 0x48
    {1'b0, 4'd4, 8'h04, 8'h08}   // R4 tx off, R2 alias took effect
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    brd(a, v);
    chk(v, exp, tag);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic pop_and_push(input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = 8'h0C; rx_valid = 1'b1; rx_data = d;
    @(negedge clk); sel = 1'b0; rx_valid = 1'b0;
    chk(rdata, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({7'b0, irq}, 8'h00, "R1 irq low");
    chk({7'b0, tx_valid}, 8'h00, "R1 tx_valid low");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) bwr(VEC[i][15:8], VEC[i][7:0]);
      else rdchk(VEC[i][15:8], VEC[i][7:0], $sformatf("R%0d vector %0d", VEC[i][19:16], i));
    end

    // R6: transmit path with backpressure
    bwr(8'h08, 8'h04);
    bwr(8'h0C, 8'h3C);
    rdchk(8'h04, 8'h04, "R6 TxEMPTY cleared");
    chk({7'b0, tx_valid}, 8'h01, "R6 offered");
    chk(tx_data, 8'h3C, "R6 data");
    repeat (3) @(negedge clk);
    chk({7'b0, tx_valid}, 8'h01, "R6 held under stall");
    chk(tx_data, 8'h3C, "R6 data held");
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk({7'b0, tx_valid}, 8'h00, "R6 accepted");
    rdchk(8'h04, 8'h0C, "R6 TxEMPTY set after accept");

    // R4: disabled transmitter keeps its byte; R5 transmitter reset drops it
    bwr(8'h08, 8'h08);
    bwr(8'h0C, 8'h77);
    chk({7'b0, tx_valid}, 8'h00, "R4 not offered while off");
    rdchk(8'h04, 8'h00, "R4 held byte, tx off");
    bwr(8'h08, 8'h04);
    chk({7'b0, tx_valid}, 8'h01, "R4 offered after enable");
    chk(tx_data, 8'h77, "R4 held data");
    bwr(8'h08, 8'h30);
    chk({7'b0, tx_valid}, 8'h00, "R5 tx reset drops byte");
    rdchk(8'h04, 8'h08, "R5 tx reset status");

    // R8 / R7: receive acceptance and FIFO order
    push(8'h99);
    rdchk(8'h04, 8'h08, "R8 dropped while rx off");
    bwr(8'h08, 8'h01);
    push(8'h10); push(8'h20); push(8'h30); push(8'h40);
    rdchk(8'h04, 8'h0B, "R7 full flag");
    push(8'h50);
    pop_and_push(8'h60, 8'h10, "R8 pop at full returns oldest");
    rdchk(8'h04, 8'h09, "R8 push at full dropped despite pop");
    rdchk(8'h0C, 8'h20, "R7 order 2");
    rdchk(8'h0C, 8'h30, "R7 order 3");
    rdchk(8'h0C, 8'h40, "R7 order 4");
    rdchk(8'h0C, 8'h00, "R7 empty read");
    rdchk(8'h04, 8'h08, "R7 RxRDY clear");

    // R12: pop and push in one cycle
    push(8'h01); push(8'h02);
    pop_and_push(8'h03, 8'h01, "R12 pop value");
    rdchk(8'h0C, 8'h02, "R12 second");
    rdchk(8'h0C, 8'h03, "R12 pushed kept");
    rdchk(8'h0C, 8'h00, "R12 level unchanged then empty");

    // R10 / R11: interrupt sources and mask
    bwr(8'h14, 8'h02);
    chk({7'b0, irq}, 8'h00, "R11 irq idle");
    push(8'hAA);
    chk({7'b0, irq}, 8'h01, "R11 irq on RxRDY");
    rdchk(8'h14, 8'h02, "R10 RxINT from RxRDY");
    bwr(8'h08, 8'h10);
    bwr(8'h00, 8'h40);
    rdchk(8'h14, 8'h00, "R10 RxINT now from full");
    chk({7'b0, irq}, 8'h00, "R11 irq off, not full");
    push(8'hBB); push(8'hCC); push(8'hDD);
    rdchk(8'h14, 8'h02, "R10 RxINT at full");
    chk({7'b0, irq}, 8'h01, "R11 irq at full");
    bwr(8'h14, 8'h01);
    chk({7'b0, irq}, 8'h00, "R11 masked off");
    bwr(8'h08, 8'h04);
    chk({7'b0, irq}, 8'h01, "R11 TxINT unmasked");
    rdchk(8'h14, 8'h03, "R10 both sources");
    bwr(8'h08, 8'h08);

    // R5: receiver reset
    bwr(8'h08, 8'h20);
    rdchk(8'h04, 8'h08, "R5 rx reset empties");
    push(8'hEE);
    rdchk(8'h04, 8'h08, "R5 rx disabled after reset");

    // R9: break into a full FIFO
    bwr(8'h08, 8'h01);
    bwr(8'h14, 8'h04);
    push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
    brk();
    rdchk(8'h14, 8'h06, "R9 break flag set");
    chk({7'b0, irq}, 8'h01, "R9 irq on break");
    rdchk(8'h0C, 8'hA1, "R9 oldest kept");
    rdchk(8'h0C, 8'hA2, "R9 second");
    rdchk(8'h0C, 8'hA3, "R9 third");
    rdchk(8'h0C, 8'h00, "R9 newest overwritten by zero");
    rdchk(8'h14, 8'h04, "R9 flag persists");
    bwr(8'h08, 8'h50);
    rdchk(8'h14, 8'h00, "R9 flag cleared");
    chk({7'b0, irq}, 8'h00, "R9 irq cleared");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule